// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block models the status side of a NOR-style flash command port. It watches chip enable, output enable and write enable on a synchronous clock. It counts the write cycles of the unlock, program and erase sequences and runs an embedded-operation timer. It reports progress in two ways. The first is a ready/busy indication, given as an active-high drive-low enable, so several instances can share one wired-AND line. The second is a toggle bit on data bit 6 of status reads.

Erase can be suspended and resumed. An erase aimed only at protected sectors toggles briefly and then falls back to array mode. A hardware reset pin aborts a running operation and holds busy through a recovery interval. Array storage is not modelled: array-mode reads return a constant fill word. All pin timing is in clock cycles, and write strobes are taken from the sampled rising edge of write enable while chip enable is low. There is no streaming data path, so every pin is plain level control with no valid/ready handshake and no back-pressure.

Top module: `flash_status_gen`

## Requirements
- R1: A program sequence (addr 0x55/data 0xAA, addr 0x2A/data 0x55, addr 0x55/data 0xA0, then any address and data) drives `rb_pull` high from the rising edge of its 4th write-enable pulse, and not after the first three. `rb_pull` stays high for PROG_CYC cycles and then drops.
- R2: Both erase sequences drive `rb_pull` high from the rising edge of the 6th write pulse. Both begin with 0x55/0xAA, 0x2A/0x55, 0x55/0x80, 0x55/0xAA, 0x2A/0x55. Chip erase ends with 0x55/0x10 and runs ERASE_CYC cycles. Sector erase ends with data 0x30 at an address whose top two bits select the sector; it runs a TOUT_CYC time-out window and then ERASE_CYC cycles.
- R3: A write whose address or data does not match the expected step returns the sequence counter to step zero, so no operation starts. A later correct sequence still works.
- R4: While `rb_pull` is high, program and erase sequences are ignored and do not change the running operation's length.
- R5: Data 0xB0 written during an erase suspends it: `rb_pull` drops and bit 6 holds steady. Data 0x30 written while suspended resumes the erase with its remaining time kept.
- R6: During a program, erase, time-out window or protected-erase run, each read cycle reads bit 6 inverted from the previous read. All other bits of the status word read 0. Outside those states bit 6 does not change between reads.
- R7: The toggle bit is already active during the sector-erase time-out window.
- R8: If every selected sector is protected (`sect_prot` bit set), the block toggles and holds `rb_pull` high for PROT_CYC cycles only, then returns to array mode (`dout` = 0xFF).
- R9: A hardware reset during an operation or a suspend aborts it and holds `rb_pull` high for RST_CYC cycles and while the pin stays low. A hardware reset while idle never raises `rb_pull`, and it clears a partly entered sequence.
- R10: After system reset `rb_pull` is 0 and `dout` returns the array fill word 0xFF.
- R11: `rb_pull` = 1 means busy; the ready line formed as the inverted OR of several instances' `rb_pull` is low whenever any instance is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low system reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable (read strobe) |
| we_n | input | 1 | Active-low write enable (write strobe) |
| hwrst_n | input | 1 | Active-low hardware reset pin |
| addr | input | ADDR_W | Command address |
| din | input | DATA_W | Command data |
| sect_prot | input | NSECT | Per-sector protect flags |
| dout | output | DATA_W | Read data: status word or array fill word |
| rb_pull | output | 1 | Drive-low enable of the ready/busy line (1 = busy) |

## Verification
The bench sweeps every sector index against every protect mask for sector erase, and every mask for chip erase. It checks mid-run whether busy is still held. A design that skipped the protection check would stay busy for a full erase; one that checked the wrong sector would misjudge the protected case. Each position of the program and erase sequences is corrupted in turn. A counter that did not restart on a mismatch would start an operation there. Other tests issue a program command during an erase, suspend an erase for far longer than it runs, and pulse the reset pin mid-operation, mid-sequence and while idle. These catch commands accepted while busy, a timer that runs on through a suspend, an operation that survives reset, and busy raised by an idle reset.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PROG,
    OP_ETOUT,
    OP_ERASE,
    OP_SUSP,
    OP_PROT,
    OP_RECOV
  } op_state_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
  } cmd_hits_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_toggling(input op_state_t s);
    return (s == OP_PROG) || (s == OP_ETOUT) || (s == OP_ERASE) || (s == OP_PROT);
  endfunction

endpackage

// File: rtl/fsg_strobe.sv
module fsg_strobe #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hwrst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              we_rise,
  output logic              rd_start,
  output logic              pin_rst,
  output logic [ADDR_W-1:0] addr_s,
  output logic [DATA_W-1:0] din_s
);

  logic we_s, we_d, oe_s, oe_d, ce_s;
  logic [SYNC_N-1:0] pin_chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_s   <= 1'b1;
      we_d   <= 1'b1;
      oe_s   <= 1'b1;
      oe_d   <= 1'b1;
      ce_s   <= 1'b1;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      we_s   <= we_n;
      we_d   <= we_s;
      oe_s   <= oe_n;
      oe_d   <= oe_s;
      ce_s   <= ce_n;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  // Reset pin synchronizer, depth chosen by parameter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_chain <= '0;
    end else begin
      for (int i = SYNC_N - 1; i > 0; i--) begin
        pin_chain[i] <= pin_chain[i-1];
      end
      pin_chain[0] <= ~hwrst_n;
    end
  end

  assign pin_rst  = pin_chain[SYNC_N-1];
  assign we_rise  = we_s & ~we_d & ~ce_s;
  assign rd_start = ~oe_s & oe_d & ~ce_s & we_s;

endmodule

// File: rtl/fsg_cmd_seq.sv
module fsg_cmd_seq
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2,
  parameter logic [ADDR_W-1:0] KEY_A     = 'h55,
  parameter logic [ADDR_W-1:0] KEY_B     = 'h2A,
  parameter logic [DATA_W-1:0] UNLK1     = 'hAA,
  parameter logic [DATA_W-1:0] UNLK2     = 'h55,
  parameter logic [DATA_W-1:0] CMD_PROG  = 'hA0,
  parameter logic [DATA_W-1:0] CMD_ERASE = 'h80,
  parameter logic [DATA_W-1:0] CMD_CHIP  = 'h10,
  parameter logic [DATA_W-1:0] CMD_SECT  = 'h30,
  parameter logic [DATA_W-1:0] CMD_SUSP  = 'hB0,
  parameter logic [DATA_W-1:0] CMD_RES   = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_rise,
  input  logic              pin_rst,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic              op_idle,
  input  logic              op_erasing,
  input  logic              op_susp,
  output cmd_hits_t         hits,
  output logic [SECT_W-1:0] sect_idx
);

  localparam int STEP_W = 3;

  logic [STEP_W-1:0] step, step_nx;
  logic              is_erase, is_erase_nx;
  logic              first_ok, second_ok;

  assign first_ok  = (addr_s == KEY_A) && (din_s == UNLK1);
  assign second_ok = (addr_s == KEY_B) && (din_s == UNLK2);
  assign sect_idx  = addr_s[ADDR_W-1 -: SECT_W];

  always_comb begin
    hits        = '0;
    step_nx     = step;
    is_erase_nx = is_erase;
    if (pin_rst) begin
      step_nx = '0;
    end else if (we_rise) begin
      if (!op_idle) begin
        step_nx = '0;
        if (op_erasing && din_s == CMD_SUSP) hits.susp = 1'b1;
        if (op_susp && din_s == CMD_RES) hits.resume = 1'b1;
      end else begin
        case (step)
          3'd0: step_nx = first_ok ? 3'd1 : 3'd0;
          3'd1: step_nx = second_ok ? 3'd2 : 3'd0;
          3'd2: begin
            if (addr_s == KEY_A && din_s == CMD_PROG) begin
              step_nx     = 3'd3;
              is_erase_nx = 1'b0;
            end else if (addr_s == KEY_A && din_s == CMD_ERASE) begin
              step_nx     = 3'd3;
              is_erase_nx = 1'b1;
            end else begin
              step_nx = 3'd0;
            end
          end
          3'd3: begin
            if (!is_erase) begin
              hits.prog = 1'b1;
              step_nx   = 3'd0;
            end else begin
              step_nx = first_ok ? 3'd4 : 3'd0;
            end
          end
          3'd4: step_nx = second_ok ? 3'd5 : 3'd0;
          3'd5: begin
            step_nx = 3'd0;
            if (addr_s == KEY_A && din_s == CMD_CHIP) hits.chip = 1'b1;
            else if (din_s == CMD_SECT) hits.sect = 1'b1;
          end
          default: step_nx = 3'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      is_erase <= 1'b0;
    end else begin
      step     <= step_nx;
      is_erase <= is_erase_nx;
    end
  end

endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
  import fsg_pkg::*;
#(
  parameter int NSECT     = 4,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 60,
  parameter int ERASE_CYC = 200,
  parameter int TOUT_CYC  = 30,
  parameter int PROT_CYC  = 50,
  parameter int RST_CYC   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_hits_t         hits,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              pin_rst,
  input  logic              rd_start,
  output op_state_t         state,
  output logic              tog
);

  localparam int MAXC  = max2(max2(max2(PROG_CYC, ERASE_CYC), max2(TOUT_CYC, PROT_CYC)), RST_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  op_state_t        st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [NSECT-1:0] sel_mask, mask_nx;
  logic [NSECT-1:0] idx_oh, blocked;
  logic             sel_all_prot, cnt_zero;

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    assign idx_oh[i]  = (sect_idx == SECT_W'(i));
    assign blocked[i] = ~sel_mask[i] | sect_prot[i];
  end

  assign sel_all_prot = &blocked;
  assign cnt_zero     = (cnt == '0);

  always_comb begin
    st_nx   = state;
    cnt_nx  = cnt;
    mask_nx = sel_mask;
    if (pin_rst) begin
      if (state != OP_IDLE && state != OP_RECOV) begin
        st_nx  = OP_RECOV;
        cnt_nx = CNT_W'(RST_CYC - 1);
      end else if (state == OP_RECOV && !cnt_zero) begin
        cnt_nx = cnt - 1'b1;
      end
    end else begin
      case (state)
        OP_IDLE: begin
          if (hits.prog) begin
            st_nx  = OP_PROG;
            cnt_nx = CNT_W'(PROG_CYC - 1);
          end else if (hits.chip) begin
            mask_nx = '1;
            if (&sect_prot) begin
              st_nx  = OP_PROT;
              cnt_nx = CNT_W'(PROT_CYC - 1);
            end else begin
              st_nx  = OP_ERASE;
              cnt_nx = CNT_W'(ERASE_CYC - 1);
            end
          end else if (hits.sect) begin
            mask_nx = idx_oh;
            st_nx   = OP_ETOUT;
            cnt_nx  = CNT_W'(TOUT_CYC - 1);
          end
        end
        OP_ETOUT: begin
          if (cnt_zero) begin
            if (sel_all_prot) begin
              st_nx  = OP_PROT;
              cnt_nx = CNT_W'(PROT_CYC - 1);
            end else begin
              st_nx  = OP_ERASE;
              cnt_nx = CNT_W'(ERASE_CYC - 1);
            end
          end else begin
            cnt_nx = cnt - 1'b1;
          end
        end
        OP_ERASE: begin
          if (hits.susp) st_nx = OP_SUSP;
          else if (cnt_zero) st_nx = OP_IDLE;
          else cnt_nx = cnt - 1'b1;
        end
        OP_SUSP: begin
          if (hits.resume) st_nx = OP_ERASE;
        end
        OP_PROG, OP_PROT, OP_RECOV: begin
          if (cnt_zero) st_nx = OP_IDLE;
          else cnt_nx = cnt - 1'b1;
        end
        default: st_nx = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= OP_IDLE;
      cnt      <= '0;
      sel_mask <= '0;
      tog      <= 1'b0;
    end else begin
      state    <= st_nx;
      cnt      <= cnt_nx;
      sel_mask <= mask_nx;
      if (rd_start && is_toggling(state)) tog <= ~tog;
    end
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NSECT     = 4,
  parameter int SYNC_N    = 2,
  parameter int PROG_CYC  = 60,
  parameter int ERASE_CYC = 200,
  parameter int TOUT_CYC  = 30,
  parameter int PROT_CYC  = 50,
  parameter int RST_CYC   = 25,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hwrst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [DATA_W-1:0] dout,
  output logic              rb_pull
);

  localparam int SECT_W  = $clog2(NSECT);
  localparam int TOG_BIT = 6;

  logic              we_rise, rd_start, pin_rst, tog;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic [SECT_W-1:0] sect_idx;
  cmd_hits_t         hits;
  op_state_t         op_state;

  fsg_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hwrst_n(hwrst_n), .addr(addr), .din(din), .we_rise(we_rise),
    .rd_start(rd_start), .pin_rst(pin_rst), .addr_s(addr_s), .din_s(din_s)
  );

  fsg_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .pin_rst(pin_rst),
    .addr_s(addr_s), .din_s(din_s),
    .op_idle(op_state == OP_IDLE),
    .op_erasing(op_state == OP_ERASE),
    .op_susp(op_state == OP_SUSP),
    .hits(hits), .sect_idx(sect_idx)
  );

  fsg_op_ctrl #(
    .NSECT(NSECT), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .TOUT_CYC(TOUT_CYC), .PROT_CYC(PROT_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hits(hits), .sect_idx(sect_idx),
    .sect_prot(sect_prot), .pin_rst(pin_rst), .rd_start(rd_start),
    .state(op_state), .tog(tog)
  );

  always_comb begin
    dout = FILL;
    if (is_toggling(op_state) || op_state == OP_SUSP) begin
      dout          = '0;
      dout[TOG_BIT] = tog;
    end
  end

  assign rb_pull = is_toggling(op_state) || (op_state == OP_RECOV);

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_rise,
  input logic              rd_start,
  input logic              pin_rst,
  input op_state_t         state,
  input logic [DATA_W-1:0] dout,
  input logic              rb_pull
);

  logic tog_st;
  assign tog_st = is_toggling(state);

  // R1 / R2: busy only ever starts from a write strobe or the reset pin
  p_busy_from_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_pull) |-> ($past(we_rise) || $past(pin_rst)))
    else $error("busy raised without a write strobe");

  // R4: a running program can only finish, continue or be reset
  p_prog_no_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OP_PROG) |=> (state == OP_PROG || state == OP_IDLE || state == OP_RECOV))
    else $error("command accepted during program");

  // R5: suspended status word does not move
  p_susp_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OP_SUSP && $past(state) == OP_SUSP) |-> $stable(dout))
    else $error("output moved during suspend");

  // R6: a read start in a toggling state flips bit 6
  p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && tog_st) |=> (!tog_st || dout[6] != $past(dout[6])))
    else $error("bit 6 failed to toggle");

  // R9: reset pin keeps a busy device busy
  p_reset_holds_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_pull && pin_rst) |=> rb_pull)
    else $error("busy dropped while reset pin held");

  // R9: reset pin while idle gives no busy
  p_idle_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OP_IDLE && pin_rst) |=> !rb_pull)
    else $error("idle reset produced busy");

endmodule

bind flash_status_gen fsg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .rd_start(rd_start),
  .pin_rst(pin_rst), .state(op_state), .dout(dout), .rb_pull(rb_pull)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 60;
  localparam int ERASE_CYC  = 200;
  localparam int TOUT_CYC   = 30;
  localparam int PROT_CYC   = 50;
  localparam int RST_CYC    = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hwrst_n = 1'b1;
  logic [7:0] addr = '0, din = '0;
  logic [3:0] sect_prot = '0;
  logic [7:0] dout, peer_dout;
  logic       rb_pull, peer_pull, line;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TOUT_CYC(TOUT_CYC),
                     .PROT_CYC(PROT_CYC), .RST_CYC(RST_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hwrst_n(hwrst_n), .addr(addr), .din(din), .sect_prot(sect_prot),
    .dout(dout), .rb_pull(rb_pull)
  );

  flash_status_gen peer (
    .clk(clk), .rst_n(rst_n), .ce_n(1'b1), .oe_n(1'b1), .we_n(1'b1),
    .hwrst_n(1'b1), .addr(8'h00), .din(8'h00), .sect_prot(4'h0),
    .dout(peer_dout), .rb_pull(peer_pull)
  );

  assign line = ~(rb_pull | peer_pull);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
    cyc(2); we_n = 1'b1;
    cyc(3); ce_n = 1'b1;
    cyc(1);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    cyc(3); v = dout; oe_n = 1'b1; ce_n = 1'b1;
    cyc(2);
  endtask

  task automatic unlock3(input logic [7:0] code);
    wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, code);
  endtask

  task automatic prog_seq();
    unlock3(8'hA0); wr(8'h13, 8'h7C);
  endtask

  task automatic erase_seq(input logic [7:0] a6, input logic [7:0] d6);
    unlock3(8'h80); wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(a6, d6);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1, v2;
    logic [7:0] pa [6];
    logic [7:0] pd [6];
    pa = '{8'h55, 8'h2A, 8'h55, 8'h55, 8'h2A, 8'h55};
    pd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};

    cyc(3); rst_n = 1'b1; cyc(2);
    // R10 reset state
    chk(rb_pull == 1'b0, "R10", "rb_pull after reset", rb_pull, 0);
    chk(dout == 8'hFF, "R10", "dout after reset", dout, 8'hFF);
    chk(line == 1'b1, "R11", "shared line idle", line, 1);

    // R1 program busy at 4th write only
    unlock3(8'hA0);
    chk(rb_pull == 1'b0, "R1", "busy after 3 writes", rb_pull, 0);
    wr(8'h13, 8'h7C);
    chk(rb_pull == 1'b1, "R1", "busy after 4th write", rb_pull, 1);
    chk(line == 1'b0, "R11", "shared line pulled low", line, 0);
    rd(v1); rd(v2);
    chk(v1[6] != v2[6], "R6", "program toggle", v2[6], !v1[6]);
    chk((v2 & 8'hBF) == 8'h00, "R6", "status other bits", v2, {1'b0, v2[6], 6'b0});
    cyc(PROG_CYC);
    chk(rb_pull == 1'b0, "R1", "program done", rb_pull, 0);
    rd(v1); rd(v2);
    chk(v1 == 8'hFF && v2 == 8'hFF, "R6", "steady after done", v2, 8'hFF);

    // R3 corrupt each program position
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        if (k == 3) wr(8'h13, 8'h7C);
        else wr(pa[k] ^ ((k == 2) ? 8'h00 : 8'h00), (k == p) ? (((k == 2) ? 8'hA0 : pd[k]) ^ 8'h01) : ((k == 2) ? 8'hA0 : pd[k]));
      end
      cyc(3);
      chk(rb_pull == 1'b0, "R3", "corrupt program position", p, 0);
    end
    // R3 corrupt each erase position
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 6; k++) wr(pa[k], (k == p) ? (pd[k] ^ 8'h01) : pd[k]);
      cyc(3);
      chk(rb_pull == 1'b0, "R3", "corrupt erase position", p, 0);
    end
    prog_seq();
    chk(rb_pull == 1'b1, "R3", "clean sequence after mismatches", rb_pull, 1);
    cyc(PROG_CYC);

    // R2 R7 R8 sector erase sweep over index and protect mask
    for (int idx = 0; idx < 4; idx++) begin
      for (int m = 0; m < 16; m++) begin
        sect_prot = 4'(m);
        erase_seq({2'(idx), 6'h05}, 8'h30);
        chk(rb_pull == 1'b1, "R2", "sector erase busy", rb_pull, 1);
        rd(v1); rd(v2);
        chk(v1[6] != v2[6], "R7", "toggle in time-out window", v2[6], !v1[6]);
        cyc(100);
        chk(rb_pull == !m[idx], "R8", "sector busy mid-run", rb_pull, !m[idx]);
        cyc(130);
        chk(rb_pull == 1'b0 && dout == 8'hFF, "R8", "sector back to array", dout, 8'hFF);
      end
    end

    // R2 R8 chip erase sweep over protect mask
    for (int m = 0; m < 16; m++) begin
      sect_prot = 4'(m);
      erase_seq(8'h55, 8'h10);
      chk(rb_pull == 1'b1, "R2", "chip erase busy", rb_pull, 1);
      rd(v1); rd(v2);
      chk(v1[6] != v2[6], "R8", "chip toggle", v2[6], !v1[6]);
      cyc(58);
      chk(rb_pull == (m != 15), "R8", "chip busy mid-run", rb_pull, m != 15);
      cyc(150);
      chk(rb_pull == 1'b0 && dout == 8'hFF, "R8", "chip back to array", dout, 8'hFF);
    end
    sect_prot = '0;

    // R4 program during erase ignored
    erase_seq(8'h55, 8'h10);
    prog_seq();
    cyc(60);
    chk(rb_pull == 1'b1, "R4", "erase still running", rb_pull, 1);
    cyc(ERASE_CYC - 80);
    chk(rb_pull == 1'b0, "R4", "erase length unchanged", rb_pull, 0);
    cyc(10);
    chk(rb_pull == 1'b0, "R4", "no program started", rb_pull, 0);

    // R5 suspend and resume
    erase_seq(8'h55, 8'h10);
    cyc(50);
    wr(8'h00, 8'hB0);
    chk(rb_pull == 1'b0, "R5", "suspend releases busy", rb_pull, 0);
    rd(v1); rd(v2);
    chk(v1 == v2 && (v2 & 8'hBF) == 8'h00, "R5", "suspend bit 6 steady", v2, v1);
    cyc(300);
    chk(rb_pull == 1'b0, "R5", "suspend holds", rb_pull, 0);
    wr(8'h00, 8'h30);
    chk(rb_pull == 1'b1, "R5", "resume busy", rb_pull, 1);
    cyc(100);
    chk(rb_pull == 1'b1, "R5", "remaining time kept", rb_pull, 1);
    cyc(60);
    chk(rb_pull == 1'b0, "R5", "resumed erase ends", rb_pull, 0);

    // R9 short reset pulse during program
    prog_seq();
    cyc(10);
    hwrst_n = 1'b0; cyc(5); hwrst_n = 1'b1;
    cyc(15);
    chk(rb_pull == 1'b1, "R9", "busy during recovery", rb_pull, 1);
    cyc(20);
    chk(rb_pull == 1'b0, "R9", "program aborted", rb_pull, 0);

    // R9 long reset pulse: busy while pin held
    prog_seq();
    cyc(10);
    hwrst_n = 1'b0; cyc(45);
    chk(rb_pull == 1'b1, "R9", "busy while pin held", rb_pull, 1);
    hwrst_n = 1'b1; cyc(8);
    chk(rb_pull == 1'b0, "R9", "released after pin", rb_pull, 0);

    // R9 reset while idle, and mid-sequence
    hwrst_n = 1'b0; cyc(3);
    chk(rb_pull == 1'b0, "R9", "idle reset early", rb_pull, 0);
    cyc(5);
    chk(rb_pull == 1'b0, "R9", "idle reset late", rb_pull, 0);
    hwrst_n = 1'b1; cyc(3);
    unlock3(8'hA0);
    hwrst_n = 1'b0; cyc(4); hwrst_n = 1'b1; cyc(3);
    wr(8'h13, 8'h7C);
    chk(rb_pull == 1'b0, "R9", "sequence cleared by reset", rb_pull, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule